// File: doc/BRIEF.md
# Reloadable Tone Period Counter

This block sets the pitch of a sound voice. It takes a control byte. The low seven bits give a reload value `R`, and the top bit is an enable. While the voice is enabled, a seven-bit counter steps upward once per full two-phase cycle. When the counter has reached 127, the next step loads `R` in place of wrapping to zero, and a one-clock tick is raised for the waveform stage that follows. The tick period is therefore `128 - R` full cycles.

A full cycle is two clock edges. At the first edge `ph2_i` is high: the next value is computed and latched. At the second edge `ph2_i` is low: the latched value is moved into the stage registers. In storage, the even-numbered stages hold their bit inverted and the odd-numbered stages hold it true. The counter and its carry chain work directly on that mixed polarity. `count_o` always presents the true value.

A small state machine tracks the counter's condition and changes only at the transfer edge:
- `ST_IDLE`: the enable is off and the counter holds the reload value.
- `ST_COUNT`: the counter is enabled and below 127.
- `ST_WRAP`: the counter is enabled and sits at 127, so the next transfer reloads.

Transitions from any state:
- To `ST_IDLE` when the latched enable is 0.
- To `ST_WRAP` when the latched next value is 127.
- To `ST_COUNT` otherwise.

Top module: `tone_period_counter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter loads `ctrl_i[6:0]` and `tick_o` is 0 once that edge has passed.
- R2: With `ctrl_i[7]`=1 and a counter value below 127, each full cycle adds exactly one to `count_o`. The edge with `ph2_i`=1 never changes `count_o`; the value changes only at the following edge with `ph2_i`=0.
- R3: With `ctrl_i[7]`=1 and `count_o`=127, the next full cycle loads `ctrl_i[6:0]` as latched at the `ph2_i`=1 edge. A reload value of 127 therefore reloads on every full cycle.
- R4: Every reload in R3 raises `tick_o` for exactly one clock, the clock that follows the `ph2_i`=0 edge that performed the reload. `tick_o` is 0 at all other times.
- R5: While `ctrl_i[7]`=0, each full cycle loads `ctrl_i[6:0]` into the counter, and `tick_o` stays 0, even when that value is 127.
- R6: Changing `ctrl_i[6:0]` while counting with the enable on does not alter the count sequence before the next reload.
- R7: With the enable held on and a constant reload value `R`, successive ticks are exactly `128 - R` full cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; two edges make one full cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_i | input | 8 | Bits 6..0: reload value; bit 7: enable |
| ph2_i | input | 1 | 1 marks the compute edge, 0 the transfer edge; alternates |
| count_o | output | 7 | Present counter value, true polarity |
| tick_o | output | 1 | One-clock pulse on each reload |

## Verification
The terminal reload and a control change can land in the same full cycle. The bench provokes this in three ways:
- It disables the counter on the very cycle in which it reaches 127, and expects a plain load with no tick.
- It runs with a reload value of 127, so that the all-ones detect and the reload coincide on every cycle and a tick must appear each time.
- It lowers the reload value on the cycle that wraps, and expects the new value to be loaded.

Each outcome is judged against a cycle-by-cycle reference model of the count and the tick.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
    localparam int unsigned TPC_WIDTH = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_WRAP  = 2'd2
    } tpc_state_e;
endpackage

// File: rtl/tpc_stage.sv
// One counter stage. INV selects inverted storage. The stage adds the
// incoming carry to its stored bit in physical polarity and passes the
// intermediate carry term on to the next stage.
module tpc_stage #(
    parameter bit INV = 1'b0
) (
    input  logic q_phys,
    input  logic carry_i,
    output logic next_phys,
    output logic carry_o
);
    generate
        if (INV) begin : g_inv
            // stored bit is the complement: XOR form keeps the complement
            assign next_phys = q_phys ^ carry_i;
            assign carry_o   = ~q_phys & carry_i;
        end else begin : g_true
            // true storage: XNOR form, inverted back
            assign next_phys = ~(q_phys ~^ carry_i);
            assign carry_o   = q_phys & carry_i;
        end
    endgenerate
endmodule

// File: rtl/tpc_alldet.sv
// Wide NAND over every stage (true polarity) plus the enable.
module tpc_alldet #(
    parameter int unsigned W = 7
) (
    input  logic [W-1:0] bits_i,
    input  logic         en_i,
    output logic         all_set_o
);
    logic nand_n;
    assign nand_n    = ~(&{en_i, bits_i});
    assign all_set_o = ~nand_n;
endmodule

// File: rtl/tone_period_counter.sv
module tone_period_counter #(
    parameter int unsigned W = tpc_pkg::TPC_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W:0]   ctrl_i,
    input  logic         ph2_i,
    output logic [W-1:0] count_o,
    output logic         tick_o
);
    import tpc_pkg::*;

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic [W-1:0] pol_mask;
    logic [W-1:0] stage_q;
    logic [W-1:0] latch_q;
    logic [W-1:0] step_phys;
    logic [W-1:0] reload_phys;
    logic [W-1:0] load_next;
    logic [W-1:0] count_l;
    logic [W:0]   carry;
    logic         en_q;
    logic         pend_q;
    logic         tick_q;
    logic         wrap;
    logic         latch_all;
    tpc_state_e   state_q;
    tpc_state_e   state_d;

    // even stages stored inverted, odd stages true
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_stage
            localparam bit INV_BIT = ((gi % 2) == 0);
            assign pol_mask[gi] = INV_BIT;
            tpc_stage #(.INV(INV_BIT)) u_stage (
                .q_phys   (stage_q[gi]),
                .carry_i  (carry[gi]),
                .next_phys(step_phys[gi]),
                .carry_o  (carry[gi+1])
            );
        end
    endgenerate

    assign carry[0]    = 1'b1;
    assign count_l     = stage_q ^ pol_mask;
    assign reload_phys = ctrl_i[W-1:0] ^ pol_mask;
    assign latch_all   = ((latch_q ^ pol_mask) == ALL_ONES);

    tpc_alldet #(.W(W)) u_alldet (
        .bits_i   (count_l),
        .en_i     (ctrl_i[W]),
        .all_set_o(wrap)
    );

    always_comb begin
        if (!ctrl_i[W] || wrap) begin
            load_next = reload_phys;
        end else begin
            load_next = step_phys;
        end
    end

    // datapath: compute at phase-2 edge, transfer at phase-1 edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= reload_phys;
            latch_q <= reload_phys;
            en_q    <= 1'b0;
            pend_q  <= 1'b0;
            tick_q  <= 1'b0;
        end else if (ph2_i) begin
            latch_q <= load_next;
            en_q    <= ctrl_i[W];
            pend_q  <= wrap;
            tick_q  <= 1'b0;
        end else begin
            stage_q <= latch_q;
            tick_q  <= pend_q;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (!ph2_i) begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_q) state_d = latch_all ? ST_WRAP : ST_COUNT;
            end
            ST_COUNT: begin
                if (!en_q)          state_d = ST_IDLE;
                else if (latch_all) state_d = ST_WRAP;
            end
            ST_WRAP: begin
                if (!en_q)           state_d = ST_IDLE;
                else if (!latch_all) state_d = ST_COUNT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        count_o = count_l;
        tick_o  = tick_q;
    end

    // R2: count never moves across a phase-2 edge
    assert_hold_phase2_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ph2_i |=> $stable(count_o));

    // R3: all-ones detect at the compute edge arms a reload
    assert_alldet_arms_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ph2_i && ctrl_i[W] && count_o == ALL_ONES) |=> pend_q);

    // R3: wrap state only when the counter shows all ones
    assert_wrap_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRAP) |-> (count_o == ALL_ONES));

    // R4: tick lasts one clock
    assert_single_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R4: an armed reload produces the tick at the transfer
    assert_pend_to_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ph2_i && pend_q) |=> tick_o);

    // R5: no tick while idle
    assert_idle_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !tick_o);
endmodule

// File: tb/test_tone_period_counter.sv
module test_tone_period_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ctrl = 8'hFC;
    logic       ph2 = 1'b1;
    logic [6:0] count;
    logic       tick;
    int         n_chk = 0;
    int         n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    tone_period_counter i_tone_period_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl_i (ctrl),
        .ph2_i  (ph2),
        .count_o(count),
        .tick_o (tick)
    );

    // {ctrl, expected count, expected tick}
    localparam logic [15:0] VEC [21] = '{
        {8'hFC, 7'd125, 1'b0}, {8'hFC, 7'd126, 1'b0}, {8'hFC, 7'd127, 1'b0},
        {8'hFC, 7'd124, 1'b1}, {8'hFC, 7'd125, 1'b0}, {8'h7C, 7'd124, 1'b0},
        {8'h10, 7'd16,  1'b0}, {8'h90, 7'd17,  1'b0}, {8'h95, 7'd18,  1'b0},
        {8'h7F, 7'd127, 1'b0}, {8'hFF, 7'd127, 1'b1}, {8'hFF, 7'd127, 1'b1},
        {8'hFE, 7'd126, 1'b1}, {8'hFE, 7'd127, 1'b0}, {8'hFE, 7'd126, 1'b1},
        {8'h80, 7'd127, 1'b0}, {8'h80, 7'd0,   1'b1}, {8'h80, 7'd1,   1'b0},
        {8'h00, 7'd0,   1'b0}, {8'h55, 7'd85,  1'b0}, {8'hD5, 7'd86,  1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // starts and ends at a falling edge
    task automatic full_cycle(input logic [7:0] c, output logic [6:0] mid_cnt,
                              output logic mid_tick);
        ctrl = c;
        ph2  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mid_cnt  = count;
        mid_tick = tick;
        ph2 = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [7:0] c);
        ctrl  = c;
        rst_n = 1'b0;
        ph2   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ph2 = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // run with enable on; check every cycle and tick spacing (R7)
    task automatic run_period(input logic [6:0] r, input int cycles, input int start);
        int   exp_c = start;
        int   last = -1;
        int   gaps = 0;
        logic [6:0] mc;
        logic mt;
        for (int k = 0; k < cycles; k++) begin
            bit p = (exp_c == 127);
            exp_c = p ? r : exp_c + 1;
            full_cycle({1'b1, r}, mc, mt);
            chk("R2 count", count, exp_c);
            chk("R4 tick", tick, p);
            if (tick) begin
                if (last >= 0) begin
                    chk("R7 spacing", k - last, 128 - r);
                    gaps++;
                end
                last = k;
            end
        end
        chk("R7 tick gaps seen", gaps > 0, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [6:0] mc;
        logic mt;
        @(negedge clk);
        do_reset(8'hFC);
        chk("R1 reset count", count, 124);
        chk("R1 reset tick", tick, 0);

        // table walk: R2 R3 R4 R5 R6
        for (int v = 0; v < 21; v++) begin
            full_cycle(VEC[v][15:8], mc, mt);
            chk($sformatf("R3/R5/R6 vec%0d count", v), count, VEC[v][7:1]);
            chk($sformatf("R4 vec%0d tick", v), tick, VEC[v][0]);
        end

        // R2: the phase-2 edge leaves the count alone and clears the tick
        full_cycle(8'hD5, mc, mt);
        chk("R2 stable at phase-2 edge", mc, 86);
        chk("R4 tick low mid-cycle", mt, 0);
        chk("R2 count after transfer", count, 87);

        // R5: disable on the all-ones cycle loads without a tick
        full_cycle(8'h7F, mc, mt);       // load 127 while disabled
        full_cycle(8'hFE, mc, mt);       // enabled: wrap to 126, tick
        chk("R3 wrap to new value", count, 126);
        full_cycle(8'hFE, mc, mt);       // 127
        full_cycle(8'h7F, mc, mt);       // disabled at 127
        chk("R5 disabled load", count, 127);
        chk("R5 no tick", tick, 0);
        full_cycle(8'h7F, mc, mt);
        chk("R5 still no tick", tick, 0);

        // R7: full period with R=0, then R=112
        full_cycle(8'h00, mc, mt);
        run_period(7'd0, 260, 0);
        full_cycle(8'h70, mc, mt);
        run_period(7'd112, 60, 112);

        // R1: reset in mid-run
        full_cycle(8'hF0, mc, mt);
        do_reset(8'hA3);
        chk("R1 mid-run reset count", count, 8'h23);
        chk("R1 mid-run reset tick", tick, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule